// File: doc/BRIEF.md
# Warm-Start Successive-Search Converter Controller

This block is the digital half of a search-type analog-to-digital converter. It puts a code on an external DAC, reads a three-way comparator that tells whether the held analog level sits above, below or on the DAC voltage, and narrows a lower/upper bracket around the answer. A conversion ends as soon as the comparator reports a match, or when a fixed number of iterations has been used. In that case the last code driven is returned.

Each conversion takes as its first guess the result of the conversion before it, not mid-scale. A slowly moving input therefore often settles in one or two iterations, while a jump still converges because the bracket is always reopened to full scale. The surrounding system issues one start pulse per sample period. The ladder, comparator and sample-and-hold sit outside the block.

The result leaves as a held register with a one-cycle done strobe. There is no back-pressure: the consumer must take the value during the strobe, or later from the held register before the next strobe.

Top module: `warm_bsearch_adc`

## Requirements
- R1: After reset, done is 0, and both result and dac_code hold mid-scale: the top bit set and all other bits clear (0x80 for N=8).
- R2: The first code driven after an accepted start equals the result register at the moment of the start. When the comparator reports a match on it at once, the conversion ends after a single iteration.
- R3: Each iteration lasts exactly two cycles. The code is put on dac_code in the first cycle and held unchanged through the second. The comparator is sampled at the end of the second cycle. A conversion of k iterations raises done 2k cycles after the start edge.
- R4: The comparator code is cmp_res = 2'b01 when the analog level is above the DAC, 2'b10 when it is below, and 2'b00 when it is equal. The value 2'b11 is also treated as equal. On equal, the driven code becomes the result and the conversion ends.
- R5: On "above" the lower bound becomes guess+1, and on "below" the upper bound becomes guess-1. The next guess is low + floor((high-low)/2). Each conversion opens the bracket at 0 and 2^N-1.
- R6: If no match occurs within ITER_MAX iterations, the conversion ends after the ITER_MAX-th comparison, and the code driven in that iteration is the result.
- R7: done is high for exactly one cycle per conversion. result changes only on the cycle done rises, and holds its value otherwise.
- R8: A start that is high while a conversion is running, including on the cycle the conversion completes, is ignored. No extra conversion and no extra done follow.
- R9: With an ideal comparator and the default ITER_MAX of N+1, every code from 0 to 2^N-1 is found exactly, in at most N+1 iterations.
- R10: A guess never leaves the bracket and never wraps. If the comparator keeps reporting "above" at full scale, or "below" at zero, the code stays at 2^N-1 or 0 until the iteration limit ends the conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion; acted on only when idle |
| cmp_res | input | 2 | Comparator outcome: 01 above, 10 below, 00 or 11 equal |
| dac_code | output | N | Code driven to the external DAC |
| result | output | N | Last conversion result, held between conversions |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
Two things can happen on the same clock edge: a conversion finishing on a match, and a new start request. The bench provokes this by holding start high across the whole one-iteration conversion of a repeated target, so start is still high on the edge that completes the conversion. The run is judged correct if exactly one done appears, the result is the target, and ten further cycles pass with no second strobe. The running case, where start arrives while the search is mid-iteration, is covered by the same stimulus on its earlier edges.

// File: rtl/adc_search_pkg.sv
`timescale 1ns/1ps
package adc_search_pkg;

  // comparator outcome as seen on cmp_res
  typedef enum logic [1:0] {
    CMP_MATCH  = 2'b00,
    CMP_ABOVE  = 2'b01,
    CMP_BELOW  = 2'b10,
    CMP_MATCH2 = 2'b11
  } cmp_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_DRIVE  = 2'b01,
    ST_SAMPLE = 2'b10
  } phase_t;

endpackage

// File: rtl/bracket_step.sv
`timescale 1ns/1ps
// Combinational narrowing of the search bracket and next midpoint.
module bracket_step #(
  parameter int N = 8
) (
  input  logic [N-1:0] guess,
  input  logic [N-1:0] low,
  input  logic [N-1:0] high,
  input  logic         go_up,
  input  logic         go_down,
  output logic [N-1:0] low_nx,
  output logic [N-1:0] high_nx,
  output logic [N-1:0] guess_nx
);
  logic [N-1:0] span;

  always_comb begin
    low_nx  = low;
    high_nx = high;
    if (go_up)
      low_nx = (guess < high) ? guess + 1'b1 : high;
    if (go_down)
      high_nx = (guess > low) ? guess - 1'b1 : low;
  end

  assign span     = high_nx - low_nx;
  assign guess_nx = low_nx + (span >> 1);
endmodule

// File: rtl/iter_limit.sv
`timescale 1ns/1ps
// Counts finished iterations and flags the last permitted one.
module iter_limit #(
  parameter int ITER_MAX = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic last
);
  localparam int CW = $clog2(ITER_MAX + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(ITER_MAX - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clear)
      cnt <= '0;
    else if (step && cnt != LAST_IDX)
      cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_IDX);

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST_IDX);
endmodule

// File: rtl/warm_bsearch_adc.sv
`timescale 1ns/1ps
module warm_bsearch_adc
  import adc_search_pkg::*;
#(
  parameter int N        = 8,
  parameter int ITER_MAX = N + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   cmp_res,
  output logic [N-1:0] dac_code,
  output logic [N-1:0] result,
  output logic         done
);
  localparam logic [N-1:0] MID_CODE = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] TOP_CODE = {N{1'b1}};

  phase_t       phase;
  logic [N-1:0] guess, low, high, result_q;
  logic [N-1:0] low_nx, high_nx, guess_nx;
  logic         done_q, last_iter, accept, matched;
  cmp_t         cmp;

  assign cmp     = cmp_t'(cmp_res);
  assign matched = (cmp != CMP_ABOVE) && (cmp != CMP_BELOW);
  assign accept  = (phase == ST_IDLE) && start;

  bracket_step #(.N(N)) u_step (
    .guess   (guess),
    .low     (low),
    .high    (high),
    .go_up   (cmp == CMP_ABOVE),
    .go_down (cmp == CMP_BELOW),
    .low_nx  (low_nx),
    .high_nx (high_nx),
    .guess_nx(guess_nx)
  );

  iter_limit #(.ITER_MAX(ITER_MAX)) u_lim (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(accept),
    .step (phase == ST_SAMPLE),
    .last (last_iter)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= ST_IDLE;
      guess    <= MID_CODE;
      low      <= '0;
      high     <= TOP_CODE;
      result_q <= MID_CODE;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase)
        ST_IDLE: if (start) begin
          guess <= result_q;
          low   <= '0;
          high  <= TOP_CODE;
          phase <= ST_DRIVE;
        end
        ST_DRIVE: phase <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (matched || last_iter) begin
            result_q <= guess;
            done_q   <= 1'b1;
            phase    <= ST_IDLE;
          end else begin
            low   <= low_nx;
            high  <= high_nx;
            guess <= guess_nx;
            phase <= ST_DRIVE;
          end
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign dac_code = guess;
  assign result   = result_q;
  assign done     = done_q;

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  // R3
  dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_SAMPLE) |-> $stable(dac_code));
  // R3
  drive_then_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_DRIVE) |=> (phase == ST_SAMPLE));
  // R2
  warm_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (dac_code == $past(result)));
  // R10
  in_bracket_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != ST_IDLE) |-> (low <= guess && guess <= high));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == ST_SAMPLE && start) |=> (phase != ST_DRIVE || !done));
endmodule

// File: tb/warm_bsearch_adc_test.sv
`timescale 1ns/1ps
module warm_bsearch_adc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, start2 = 1'b0;
  logic [7:0] ana = 8'd0, ana2 = 8'd0;
  int         mode = 0;
  logic [1:0] cmp, cmp2;
  logic [7:0] dac, res, dac2, res2;
  logic       done, done2;
  int         checks = 0, fails = 0;
  logic [7:0] glog [0:31];
  int         gcount;

  always #2.5 clk = ~clk;

  assign cmp = (mode == 1) ? 2'b01 : (mode == 2) ? 2'b10 : (mode == 3) ? 2'b11 :
               (ana > dac) ? 2'b01 : (ana < dac) ? 2'b10 : 2'b00;
  assign cmp2 = (ana2 > dac2) ? 2'b01 : (ana2 < dac2) ? 2'b10 : 2'b00;

  warm_bsearch_adc #(.N(8)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_res(cmp),
    .dac_code(dac), .result(res), .done(done));

  warm_bsearch_adc #(.N(8), .ITER_MAX(2)) uut_lim (
    .clk(clk), .rst_n(rst_n), .start(start2), .cmp_res(cmp2),
    .dac_code(dac2), .result(res2), .done(done2));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [7:0] tgt, output int cyc);
    ana = tgt;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    glog[0] = dac; gcount = 1; cyc = 0;
    while (cyc < 100) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (done) break;
      if (cyc % 2 == 0 && gcount < 32) begin glog[gcount] = dac; gcount++; end
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(res == 8'h80, "R1 result", res, 128);
    chk(dac == 8'h80, "R1 dac_code", dac, 128);
  endtask

  task automatic t_cold_trace;
    int cyc;
    run_conv(8'd200, cyc);
    chk(glog[0] == 8'd128, "R2 first guess mid-scale", glog[0], 128);
    chk(cyc == 10, "R3 five iterations take 10 cycles", cyc, 10);
    chk(res == 8'd200, "R4 match captured", res, 200);
    chk(gcount == 5, "R5 guess count", gcount, 5);
    chk(glog[1] == 8'd192, "R5 guess 2", glog[1], 192);
    chk(glog[2] == 8'd224, "R5 guess 3", glog[2], 224);
    chk(glog[3] == 8'd208, "R5 guess 4", glog[3], 208);
    chk(glog[4] == 8'd200, "R5 guess 5", glog[4], 200);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk(res == 8'd200, "R7 result held", res, 200);
  endtask

  task automatic t_warm_repeat;
    int cyc;
    run_conv(8'd200, cyc);
    chk(glog[0] == 8'd200, "R2 warm first guess", glog[0], 200);
    chk(cyc == 2, "R2 repeat target one iteration", cyc, 2);
  endtask

  task automatic t_alt_equal;
    int cyc;
    mode = 3;
    run_conv(8'd50, cyc);
    mode = 0;
    chk(cyc == 2, "R4 code 11 counts as equal", cyc, 2);
    chk(res == 8'd200, "R4 code 11 keeps guess", res, 200);
  endtask

  task automatic t_random;
    int cyc;
    logic [7:0] t;
    for (int i = 0; i < 24; i++) begin
      t = (i == 0) ? 8'd0 : (i == 1) ? 8'd255 : 8'($urandom_range(255, 0));
      run_conv(t, cyc);
      chk(res == t, "R9 exact result", res, t);
      chk(cyc <= 18, "R9 iteration bound", cyc, 18);
    end
  endtask

  task automatic t_edges;
    int cyc;
    run_conv(8'd255, cyc);
    mode = 1;
    run_conv(8'd255, cyc);
    mode = 0;
    chk(cyc == 18, "R10 stuck above runs to limit", cyc, 18);
    chk(res == 8'd255, "R10 no wrap at top", res, 255);
    run_conv(8'd0, cyc);
    mode = 2;
    run_conv(8'd0, cyc);
    mode = 0;
    chk(cyc == 18, "R10 stuck below runs to limit", cyc, 18);
    chk(res == 8'd0, "R10 no wrap at zero", res, 0);
  endtask

  task automatic lim_conv(input logic [7:0] tgt, output int cyc);
    ana2 = tgt;
    @(negedge clk); start2 = 1'b1;
    @(posedge clk);
    @(negedge clk); start2 = 1'b0;
    cyc = 0;
    while (cyc < 100) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (done2) break;
    end
  endtask

  task automatic t_limit;
    int cyc;
    lim_conv(8'd200, cyc);
    chk(cyc == 4, "R6 limit of two iterations", cyc, 4);
    chk(res2 == 8'd192, "R6 last guess returned", res2, 192);
    lim_conv(8'd100, cyc);
    chk(cyc == 4, "R6 limit second run", cyc, 4);
    chk(res2 == 8'd95, "R6 last guess from warm start", res2, 95);
  endtask

  task automatic t_busy_same_cycle;
    int cyc;
    int extra = 0;
    run_conv(8'd77, cyc);
    @(negedge clk); start = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R8 done with start held", done, 1);
    start = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R8 start while busy ignored", extra, 0);
    chk(res == 8'd77, "R8 result kept", res, 77);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_cold_trace();
    t_warm_repeat();
    t_alt_equal();
    t_random();
    t_edges();
    t_limit();
    t_busy_same_cycle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule